// File: doc/BRIEF.md
# Unified Set-Associative Cache Core

This block is the lookup and allocation engine of a unified second-level cache. Instruction fetches and data accesses from split first-level caches share one set-associative store. The core accepts one word-sized request at a time: a byte address, a read/write flag and write data. The tag array is always consulted first. The data array is touched afterwards, and only for the single way that was selected. That way is the hitting way, or the victim chosen on a miss.

On a miss the victim is the lowest-numbered empty way in the set. When the set is full, the victim is the least recently used way, tracked with a true LRU age per way. A modified victim is written back as a whole line before the new line is fetched over a simple request/acknowledge memory port. Tags carry a parity bit computed by the core. Data lines carry a parity bit delivered with the fill. A parity failure on a hit turns that access into a miss, raises a flag in the response and refetches the line.

Top module: `ucache_core`

## Requirements
- R1: After reset `reqReady`=1, `respValid`=0, `memReqValid`=0, and every line is invalid, so the first access to any address is answered with `respHit`=0.
- R2: A request is taken on a rising edge with `reqValid`=1 and `reqReady`=1. `reqReady` stays low until the response. Each accepted request produces exactly one single-cycle `respValid` pulse.
- R3: A read hit is answered with `respHit`=1 after the second rising edge that follows the acceptance edge, without any memory request.
- R4: Address fields: the byte offset in the line is `addr[OFF_W-1:0]`, the word is `addr[OFF_W-1:2]`, the set is the next `SET_W` bits and the tag is the remaining upper bits. A read returns the most recently written value of its 32-bit word, or the memory content if that word was never written.
- R5: A write hit replaces the addressed word, marks the line modified and answers with `respHit`=1 and `respRdata` equal to the written word.
- R6: On a miss, the lowest-numbered invalid way is filled. If the set is full, the way least recently hit or filled is replaced. Every hit and every fill makes its way the most recent.
- R7: A modified victim is written back before the fill. The write-back is a request with `memReqWrite`=1, the victim's line-aligned address and the full line. A clean victim causes no write request.
- R8: `memReqValid`, `memReqWrite` and `memReqAddr` hold steady until `memAck`. A fill read request has `memReqWrite`=0 and a line-aligned address (low `OFF_W` bits zero), and follows the write-back directly.
- R9: A write miss fetches the line, merges the written word into it and leaves the line modified. The other words keep their memory values.
- R10: Parity is even: a stored line is good when the XOR of its bits equals its parity bit. A fill stores `memRparity` as delivered. A hit whose stored tag or data parity is bad is answered with `respParityErr`=1 and `respHit`=0, after the line is invalidated and refetched. The response data comes from the refetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Core idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the word |
| reqWdata | input | WORD_W | Write data |
| respValid | output | 1 | One-cycle response pulse |
| respHit | output | 1 | Request was served without a fill |
| respParityErr | output | 1 | A stored parity failure was found |
| respRdata | output | WORD_W | Read word, or the written word for writes |
| memReqValid | output | 1 | Memory request pending |
| memReqWrite | output | 1 | 1 = write-back, 0 = line fill |
| memReqAddr | output | ADDR_W | Line-aligned memory address |
| memWdata | output | LINE_W | Line written back |
| memAck | input | 1 | Memory completes the pending request |
| memRdata | input | LINE_W | Fill line, valid with memAck |
| memRparity | input | 1 | Even parity bit of the fill line |

## Verification
The bench builds the core with four sets and otherwise default parameters: four ways of 32-byte lines, 16 lines in all. A handful of accesses to one set therefore exhausts its ways, and both clean and modified evictions occur within a short directed sequence. A pseudo-random phase spreads six tags over each set, more than the associativity, so reads after eviction, write-backs of merged words and LRU reordering are exercised continuously. The memory model also delivers one fill with a deliberately wrong parity bit, which brings the parity-forced miss within reach.

// File: rtl/ucache_pkg.sv
package ucache_pkg;

  // Strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic latchReq;    // capture the incoming request
    logic capLookup;   // register the lookup result, drop bad tags
    logic hitCommit;   // finish a hit: respond, update line and LRU
    logic dataErrInv;  // drop the selected way after a data parity failure
    logic fillCommit;  // install the fetched line, respond, update LRU
    logic wbSel;       // memory address is the victim line
  } ctrl_strobe_t;

  // Lookup facts returned by the datapath
  typedef struct packed {
    logic hit;
    logic victimDirty;
    logic dataErr;
  } dp_status_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_DATA,
    ST_WBACK,
    ST_FILL
  } ctrl_state_t;

endpackage

// File: rtl/ucache_ctrl.sv
module ucache_ctrl
  import ucache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memAck,
  input  dp_status_t   stat,
  output ctrl_strobe_t strb,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         memReqWrite
);

  ctrl_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.latchReq = 1'b1;
          stateNext     = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        strb.capLookup = 1'b1;
        if (stat.hit)              stateNext = ST_DATA;
        else if (stat.victimDirty) stateNext = ST_WBACK;
        else                       stateNext = ST_FILL;
      end
      ST_DATA: begin
        if (stat.dataErr) begin
          strb.dataErrInv = 1'b1;
          stateNext       = ST_FILL;
        end else begin
          strb.hitCommit = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      ST_WBACK: begin
        strb.wbSel = 1'b1;
        if (memAck) stateNext = ST_FILL;
      end
      ST_FILL: begin
        if (memAck) begin
          strb.fillCommit = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_WBACK) || (state == ST_FILL);
  assign memReqWrite = (state == ST_WBACK);

endmodule

// File: rtl/ucache_dp.sv
module ucache_dp
  import ucache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strb,
  output dp_status_t          stat,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [WORD_W-1:0]   reqWdata,
  output logic                respValid,
  output logic                respHit,
  output logic                respParityErr,
  output logic [WORD_W-1:0]   respRdata,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [LINE_W-1:0]   memWdata,
  input  logic [LINE_W-1:0]   memRdata,
  input  logic                memRparity
);

  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int WIX_W  = $clog2(LINE_WORDS);
  localparam int OFF_W  = BOFF_W + WIX_W;
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int AGE_W  = WAY_W;

  // Behavioural storage
  logic              validArr [SETS][WAYS];
  logic              dirtyArr [SETS][WAYS];
  logic [TAG_W-1:0]  tagArr   [SETS][WAYS];
  logic              tagPar   [SETS][WAYS];
  logic [LINE_W-1:0] dataArr  [SETS][WAYS];
  logic              dataPar  [SETS][WAYS];
  logic [AGE_W-1:0]  ageArr   [SETS][WAYS];

  // Captured request
  logic [TAG_W-1:0]  rTag;
  logic [SET_W-1:0]  rSet;
  logic [WIX_W-1:0]  rWix;
  logic              rWrite;
  logic [WORD_W-1:0] rWdata;
  logic              unusedByteOff;

  assign unusedByteOff = ^reqAddr[BOFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rTag   <= '0;
      rSet   <= '0;
      rWix   <= '0;
      rWrite <= 1'b0;
      rWdata <= '0;
    end else if (strb.latchReq) begin
      rTag   <= reqAddr[ADDR_W-1 -: TAG_W];
      rSet   <= reqAddr[OFF_W +: SET_W];
      rWix   <= reqAddr[BOFF_W +: WIX_W];
      rWrite <= reqWrite;
      rWdata <= reqWdata;
    end
  end

  // Tag lookup, one comparator per way
  logic [WAYS-1:0] wayValid, wayErr, wayMatch;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayValid[w] = validArr[rSet][w];
    assign wayErr[w]   = wayValid[w] &&
                         (tagPar[rSet][w] != ^{dirtyArr[rSet][w], tagArr[rSet][w]});
    assign wayMatch[w] = wayValid[w] && !wayErr[w] && (tagArr[rSet][w] == rTag);
  end

  logic [WAY_W-1:0] hitWay, victimWay;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (wayMatch[w]) hitWay = WAY_W'(w);
    victimWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (ageArr[rSet][w] == AGE_W'(WAYS - 1)) victimWay = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!(wayValid[w] && !wayErr[w])) victimWay = WAY_W'(w);
  end

  // Way chosen for the rest of the request
  logic [WAY_W-1:0] selWay;
  logic [TAG_W-1:0] selTag;
  logic             parFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selWay  <= '0;
      selTag  <= '0;
      parFlag <= 1'b0;
    end else begin
      if (strb.latchReq) parFlag <= 1'b0;
      if (strb.capLookup) begin
        selWay <= stat.hit ? hitWay : victimWay;
        selTag <= tagArr[rSet][victimWay];
        if (|wayErr) parFlag <= 1'b1;
      end
      if (strb.dataErrInv) parFlag <= 1'b1;
    end
  end

  // Data access for the selected way only
  logic [LINE_W-1:0] curLine, hitLine, fillLine;
  logic [WORD_W-1:0] curWord, fillWord;

  function automatic logic [LINE_W-1:0] putWord(input logic [LINE_W-1:0] base,
                                                input logic [WIX_W-1:0]  ix,
                                                input logic [WORD_W-1:0] wd);
    logic [LINE_W-1:0] res;
    res = base;
    res[ix*WORD_W +: WORD_W] = wd;
    return res;
  endfunction

  assign curLine  = dataArr[rSet][selWay];
  assign curWord  = curLine[rWix*WORD_W +: WORD_W];
  assign fillWord = memRdata[rWix*WORD_W +: WORD_W];
  assign hitLine  = putWord(curLine, rWix, rWdata);
  assign fillLine = rWrite ? putWord(memRdata, rWix, rWdata) : memRdata;

  assign stat.hit         = (|wayMatch) && !(|wayErr);
  assign stat.victimDirty = wayValid[victimWay] && !wayErr[victimWay] &&
                            dirtyArr[rSet][victimWay];
  assign stat.dataErr     = (^curLine) != dataPar[rSet][selWay];

  // Tag, state and LRU storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          validArr[s][w] <= 1'b0;
          dirtyArr[s][w] <= 1'b0;
          tagArr[s][w]   <= '0;
          tagPar[s][w]   <= 1'b0;
          ageArr[s][w]   <= AGE_W'(w);
        end
    end else begin
      if (strb.capLookup)
        for (int w = 0; w < WAYS; w++)
          if (wayErr[w]) validArr[rSet][w] <= 1'b0;
      if (strb.dataErrInv) validArr[rSet][selWay] <= 1'b0;
      if (strb.hitCommit && rWrite) begin
        dirtyArr[rSet][selWay] <= 1'b1;
        tagPar[rSet][selWay]   <= ^{1'b1, tagArr[rSet][selWay]};
      end
      if (strb.fillCommit) begin
        validArr[rSet][selWay] <= 1'b1;
        dirtyArr[rSet][selWay] <= rWrite;
        tagArr[rSet][selWay]   <= rTag;
        tagPar[rSet][selWay]   <= ^{rWrite, rTag};
      end
      if (strb.hitCommit || strb.fillCommit)
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == selWay)
            ageArr[rSet][w] <= '0;
          else if (ageArr[rSet][w] < ageArr[rSet][selWay])
            ageArr[rSet][w] <= ageArr[rSet][w] + 1'b1;
        end
    end
  end

  // Line storage has no reset; validity guards it
  always_ff @(posedge clk) begin
    if (strb.hitCommit && rWrite) begin
      dataArr[rSet][selWay] <= hitLine;
      dataPar[rSet][selWay] <= ^hitLine;
    end
    if (strb.fillCommit) begin
      dataArr[rSet][selWay] <= fillLine;
      dataPar[rSet][selWay] <= rWrite ? ^fillLine : memRparity;
    end
  end

  // Response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respHit       <= 1'b0;
      respParityErr <= 1'b0;
      respRdata     <= '0;
    end else begin
      respValid <= strb.hitCommit || strb.fillCommit;
      if (strb.hitCommit) begin
        respHit       <= 1'b1;
        respParityErr <= parFlag;
        respRdata     <= rWrite ? rWdata : curWord;
      end else if (strb.fillCommit) begin
        respHit       <= 1'b0;
        respParityErr <= parFlag;
        respRdata     <= rWrite ? rWdata : fillWord;
      end
    end
  end

  assign memReqAddr = strb.wbSel ? {selTag, rSet, {OFF_W{1'b0}}}
                                 : {rTag,   rSet, {OFF_W{1'b0}}};
  assign memWdata   = curLine;

endmodule

// File: rtl/ucache_core.sv
module ucache_core
  import ucache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  output logic              respValid,
  output logic              respHit,
  output logic              respParityErr,
  output logic [WORD_W-1:0] respRdata,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [LINE_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [LINE_W-1:0] memRdata,
  input  logic              memRparity
);

  ctrl_strobe_t strb;
  dp_status_t   stat;

  ucache_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memAck      (memAck),
    .stat        (stat),
    .strb        (strb),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite)
  );

  ucache_dp #(
    .ADDR_W     (ADDR_W),
    .SETS       (SETS),
    .WAYS       (WAYS),
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .stat          (stat),
    .reqWrite      (reqWrite),
    .reqAddr       (reqAddr),
    .reqWdata      (reqWdata),
    .respValid     (respValid),
    .respHit       (respHit),
    .respParityErr (respParityErr),
    .respRdata     (respRdata),
    .memReqAddr    (memReqAddr),
    .memWdata      (memWdata),
    .memRdata      (memRdata),
    .memRparity    (memRparity)
  );

endmodule

// File: rtl/ucache_core_chk.sv
module ucache_core_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              respValid,
  input logic              respHit,
  input logic              respParityErr,
  input logic              memReqValid,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memAck
);

  // R8: a pending memory request is held until acknowledged
  a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memAck |=> memReqValid && $stable(memReqAddr) && $stable(memReqWrite));

  // R7: an acknowledged write-back is followed at once by the fill read
  a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite && memAck |=> memReqValid && !memReqWrite);

  // R3: a hit never used the memory port in the cycle before its response
  a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respHit |-> $past(!memReqValid));

  // R10: a parity-forced access is never reported as a hit
  a_r10_parity_not_hit: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respParityErr |-> !respHit);

  // R2: memory traffic only while a request is in progress
  a_r2_mem_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R2: a response follows a busy cycle
  a_r2_resp_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(!reqReady));

endmodule

bind ucache_core ucache_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqReady      (reqReady),
  .respValid     (respValid),
  .respHit       (respHit),
  .respParityErr (respParityErr),
  .memReqValid   (memReqValid),
  .memReqWrite   (memReqWrite),
  .memReqAddr    (memReqAddr),
  .memAck        (memAck)
);

// File: tb/ucache_core_bench.sv
module ucache_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int NSETS      = 4;
  localparam int WAYS       = 4;
  localparam int LWORDS     = 8;
  localparam int LINE_W     = 32 * LWORDS;
  localparam int OFF        = 5;
  localparam int SETB       = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0]       reqWdata = '0;
  logic              reqReady, respValid, respHit, respParityErr;
  logic [31:0]       respRdata;
  logic              memReqValid, memReqWrite;
  logic [ADDR_W-1:0] memReqAddr;
  logic [LINE_W-1:0] memWdata;
  logic              memAck = 1'b0;
  logic [LINE_W-1:0] memRdata = '0;
  logic              memRparity = 1'b0;

  ucache_core #(.ADDR_W(ADDR_W), .SETS(NSETS), .WAYS(WAYS), .WORD_W(32), .LINE_WORDS(LWORDS))
  u_ucache_core (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .respValid(respValid), .respHit(respHit),
    .respParityErr(respParityErr), .respRdata(respRdata), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .memRparity(memRparity)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Reference state: memory image, CPU-visible words, per-set recency lists
  logic [LINE_W-1:0] mainMem [int];
  logic [31:0]       refMem  [int];
  int                order   [NSETS][$];
  bit                dirtyMap[int];
  bit                badMap  [int];
  int                expWb   [$];
  int                corruptLine = -1;
  int                memOps = 0;

  function automatic logic [31:0] defWord(input int wa);
    logic [31:0] x;
    x = 32'(wa);
    return (x * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [31:0] refRead(input int wa);
    if (refMem.exists(wa)) return refMem[wa];
    return defWord(wa);
  endfunction

  function automatic logic [LINE_W-1:0] memLine(input int ln);
    logic [LINE_W-1:0] r;
    if (mainMem.exists(ln)) return mainMem[ln];
    for (int w = 0; w < LWORDS; w++) r[w*32 +: 32] = defWord(ln * LWORDS + w);
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] refLine(input int ln);
    logic [LINE_W-1:0] r;
    for (int w = 0; w < LWORDS; w++) r[w*32 +: 32] = refRead(ln * LWORDS + w);
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input int tg, input int st, input int wd);
    return ADDR_W'((tg << (OFF + SETB)) | (st << OFF) | (wd << 2));
  endfunction

  // Memory responder: acknowledges after three cycles of a pending request
  initial begin : responder
    int waitCnt = 0;
    logic [ADDR_W-1:0] heldAddr = '0;
    logic heldWr = 1'b0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck  = 1'b0;
        waitCnt = 0;
      end else if (memReqValid) begin
        if (waitCnt == 0) begin
          heldAddr = memReqAddr;
          heldWr   = memReqWrite;
          chk(memReqAddr[OFF-1:0] == '0, "R8", "memory address aligned",
              64'(memReqAddr[OFF-1:0]), 64'd0);
        end else begin
          chk(memReqAddr == heldAddr && memReqWrite == heldWr, "R8", "request held",
              64'({memReqWrite, memReqAddr}), 64'({heldWr, heldAddr}));
        end
        waitCnt++;
        if (waitCnt >= 3) begin
          int ln;
          ln = int'(memReqAddr >> OFF);
          memAck = 1'b1;
          memOps++;
          if (memReqWrite) begin
            if (expWb.size() == 0) begin
              chk(1'b0, "R7", "unexpected write-back", 64'(memReqAddr), 64'd0);
            end else begin
              int e;
              e = expWb.pop_front();
              chk(ln == e, "R7", "write-back line", 64'(ln), 64'(e));
              chk(memWdata == refLine(ln), "R7", "write-back data",
                  64'(memWdata[63:0]), 64'(refLine(ln)));
            end
            mainMem[ln] = memWdata;
          end else begin
            memRdata   = memLine(ln);
            memRparity = (^memRdata) ^ (ln == corruptLine);
            if (ln == corruptLine) corruptLine = -1;
          end
        end
      end
    end
  end

  task automatic doReq(input bit wr, input logic [ADDR_W-1:0] addr, input logic [31:0] wd,
                       input bit corrupt, input string hitTag);
    int ln, st, tg, idx, lat, opsBefore;
    bit expHit, expPe;
    logic [31:0] expData;
    ln = int'(addr >> OFF);
    st = ln % NSETS;
    tg = ln / NSETS;
    idx = -1;
    expPe = 1'b0;
    for (int i = 0; i < order[st].size(); i++) if (order[st][i] == tg) idx = i;
    if (idx >= 0 && !badMap.exists(ln)) begin
      expHit = 1'b1;
      order[st].delete(idx);
      order[st].push_front(tg);
      if (wr) dirtyMap[ln] = 1'b1;
    end else begin
      expHit = 1'b0;
      if (idx >= 0) begin
        expPe = 1'b1;
        order[st].delete(idx);
        badMap.delete(ln);
        dirtyMap.delete(ln);
      end
      if (order[st].size() == WAYS) begin
        int v, vl;
        v  = order[st].pop_back();
        vl = v * NSETS + st;
        if (dirtyMap.exists(vl) && dirtyMap[vl]) expWb.push_back(vl);
        dirtyMap.delete(vl);
        badMap.delete(vl);
      end
      order[st].push_front(tg);
      dirtyMap[ln] = wr;
      if (corrupt) begin
        badMap[ln]  = 1'b1;
        corruptLine = ln;
      end
    end

    @(negedge clk);
    while (!reqReady) @(negedge clk);
    opsBefore = memOps;
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = addr;
    reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    // Write-back data compare needs the old image, so update after the fill
    lat = 0;
    while (!respValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    if (wr) begin
      refMem[int'(addr >> 2)] = wd;
      expData = wd;
    end else begin
      expData = refRead(int'(addr >> 2));
    end
    chk(respValid, "R2", "response arrives", 64'(respValid), 64'd1);
    chk(respRdata == expData, wr ? "R5" : "R4", "response data",
        64'(respRdata), 64'(expData));
    chk(respHit == expHit, hitTag, "hit flag", 64'(respHit), 64'(expHit));
    chk(respParityErr == expPe, "R10", "parity flag", 64'(respParityErr), 64'(expPe));
    if (expHit) begin
      chk(lat == 2, "R3", "hit latency", 64'(lat), 64'd2);
      chk(memOps == opsBefore, "R3", "no memory on hit", 64'(memOps), 64'(opsBefore));
    end
    @(negedge clk);
    chk(!respValid, "R2", "single response pulse", 64'(respValid), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R2", "watchdog expired", 64'd0, 64'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "ready after reset", 64'(reqReady), 64'd1);
    chk(respValid == 1'b0, "R1", "no response after reset", 64'(respValid), 64'd0);
    chk(memReqValid == 1'b0, "R1", "no memory request after reset", 64'(memReqValid), 64'd0);

    // R1: first access misses; R3: repeat hits
    doReq(0, mk(1, 0, 3), '0, 0, "R1");
    doReq(0, mk(1, 0, 3), '0, 0, "R3");
    // R5: write hit and read back
    doReq(1, mk(1, 0, 5), 32'hCAFE0001, 0, "R5");
    doReq(0, mk(1, 0, 5), '0, 0, "R5");
    // R9: write miss merges into fetched line
    doReq(1, mk(2, 0, 1), 32'hBEEF0202, 0, "R9");
    doReq(0, mk(2, 0, 1), '0, 0, "R9");
    doReq(0, mk(2, 0, 6), '0, 0, "R9");
    // R6: fill set 1, touch tag 1, then conflicts follow LRU order
    for (int t = 1; t <= 4; t++) doReq(0, mk(t, 1, 0), '0, 0, "R6");
    doReq(0, mk(1, 1, 2), '0, 0, "R6");
    doReq(0, mk(5, 1, 0), '0, 0, "R6");
    doReq(0, mk(3, 1, 0), '0, 0, "R6");
    doReq(0, mk(2, 1, 0), '0, 0, "R6");
    doReq(0, mk(1, 1, 0), '0, 0, "R6");
    doReq(0, mk(4, 1, 0), '0, 0, "R6");
    // R7: modified lines of set 0 get evicted and written back
    for (int t = 3; t <= 6; t++) doReq(0, mk(t, 0, 0), '0, 0, "R7");
    doReq(0, mk(1, 0, 5), '0, 0, "R7");
    doReq(0, mk(2, 0, 1), '0, 0, "R7");
    // R10: fill with bad parity, next hit is forced to a refetch
    doReq(0, mk(7, 2, 0), '0, 1, "R10");
    doReq(0, mk(7, 2, 4), '0, 0, "R10");
    doReq(0, mk(7, 2, 4), '0, 0, "R10");

    // R4: pseudo-random mixed traffic over all sets
    lfsr = 32'h1234_5677;
    for (int n = 0; n < 400; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      doReq(lfsr[12], mk(int'(lfsr[2:0]) % 6, int'(lfsr[5:4]), int'(lfsr[10:8])),
            lfsr ^ 32'h0F0F_0F0F, 0, "R4");
    end

    repeat (5) @(negedge clk);
    chk(expWb.size() == 0, "R7", "all write-backs seen", 64'(expWb.size()), 64'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule